// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block sits between a memory requester and two memory targets, system RAM and the PCI bus. It steers every transaction that falls in the legacy firmware window (addresses 0xC0000 to 0xFFFFF of a 20-bit space) to one of the two targets. The choice depends on the transaction direction and on a bank of seven programmable 8-bit attribute registers. Any address below the window always goes to RAM.

Each 4-bit attribute field holds a mode. Bit 0 of the mode sends reads to RAM and bit 1 sends writes to RAM; a cleared bit sends that direction to PCI. Because reads and writes are steered separately, the requester can copy a firmware image into shadow RAM. It selects mode 2 (read PCI, write RAM), reads each word and writes it straight back to the same address, then selects mode 3 so that later reads are served from RAM.

The request, downstream request and upstream response interfaces are valid/ready. A beat transfers in a cycle where both valid and ready are high. A raised valid, and the payload with it, holds steady until the matching ready. The block accepts one transaction at a time, so `up_ready` stays low from acceptance until that transaction completes. Downstream read responses carry no ready signal: a target may only return data for a read the block has issued to it. The block then captures that data and offers it upstream on `up_rsp_*`, where it holds until `up_rsp_ready`. Writes give no upstream response.

Top module: `shadow_route_top`

## Requirements
- R1: After reset all seven attribute registers read 0x00, no downstream request is pending, `up_ready` is high and `up_rsp_valid` is low, so every window access goes to PCI.
- R2: A configuration write with `cfg_wr_en` high stores `cfg_wdata` in register `cfg_idx` (0 to 6), and `cfg_rdata` then shows the stored value for the selected index. This includes the low field of register 0, which has no routing effect.
- R3: For a window address, the selected 4-bit field decides the target. A read goes to RAM when field bit 0 is 1, and a write goes to RAM when field bit 1 is 1. Otherwise the access goes to PCI, so mode 0 is all PCI, mode 1 is read RAM and write PCI, mode 2 is read PCI and write RAM, and mode 3 is all RAM.
- R4: For addresses 0xC0000 to 0xEFFFF, the controlling register index is address bits [17:15] plus 1. Address bit 14 picks the field: 0 selects bits [3:0] and 1 selects bits [7:4].
- R5: Addresses 0xF0000 to 0xFFFFF are controlled by bits [7:4] of register 0. Bits [3:0] of register 0 never affect routing.
- R6: Any address below 0xC0000 goes to RAM whatever the register contents.
- R7: The target is fixed when the request is accepted. A configuration write made while that request waits downstream does not change its target.
- R8: Each accepted request produces exactly one downstream request, on exactly one of the two targets. `up_ready` stays low until the request completes.
- R9: A downstream request keeps its valid, address, direction and write data stable while its ready is low.
- R10: A read returns the data of the target it was sent to on `up_rsp_data`. That data and `up_rsp_valid` hold stable while `up_rsp_ready` is low.
- R11: A mode 2 read followed by a write of the returned value to the same address places the PCI data in RAM. A later mode 3 read of that address returns it.
- R12: A write completes when the target accepts it. `up_ready` is high again the cycle after, and no upstream response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Attribute register write strobe |
| cfg_idx | input | 3 | Attribute register index (0 to 6) |
| cfg_wdata | input | 8 | Attribute register write value |
| cfg_rdata | output | 8 | Value of the register at `cfg_idx` (0 for unused indices) |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request ready |
| up_addr | input | ADDR_W | Upstream byte address |
| up_we | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DATA_W | Upstream write data |
| up_rsp_valid | output | 1 | Read data valid |
| up_rsp_ready | input | 1 | Read data accepted |
| up_rsp_data | output | DATA_W | Read data |
| dn_addr | output | ADDR_W | Downstream address, shared by both targets |
| dn_we | output | 1 | Downstream direction |
| dn_wdata | output | DATA_W | Downstream write data |
| ram_req_valid | output | 1 | RAM request valid |
| ram_req_ready | input | 1 | RAM request ready |
| ram_rsp_valid | input | 1 | RAM read data valid |
| ram_rsp_data | input | DATA_W | RAM read data |
| pci_req_valid | output | 1 | PCI request valid |
| pci_req_ready | input | 1 | PCI request ready |
| pci_rsp_valid | input | 1 | PCI read data valid |
| pci_rsp_data | input | DATA_W | PCI read data |

## Verification
A request accepted at one clock edge shows its downstream valid in the following cycle. A write releases `up_ready` in the cycle after the target accepts it. A read raises `up_rsp_valid` the cycle after the target returns data; the bench's target models return data one cycle after accepting a read. Configuration writes are visible on `cfg_rdata`, and take effect for the next accepted request, one edge after the strobe. The bench drives and samples only on falling edges, and waits for `up_ready` or `up_rsp_valid` instead of assuming a fixed count. It reads the target that was chosen from per-target acceptance counters, which are updated at the downstream handshake edge. When it holds a stall to test back-pressure, it checks stability over several falling edges.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // number of attribute registers and their width
  localparam int ATTR_REGS = 7;
  localparam int ATTR_W    = 8;
  localparam int FIELD_W   = 4;
  localparam int IDX_W     = $clog2(ATTR_REGS);
  // top address bits inspected by the segment decode
  localparam int DEC_BITS  = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } txn_state_e;
endpackage

// File: rtl/shadow_attr_bank.sv
module shadow_attr_bank
  import shadow_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            idx,
  input  logic [ATTR_W-1:0]           wdata,
  output logic [ATTR_W-1:0]           rdata,
  output logic [ATTR_REGS*ATTR_W-1:0] attr_flat
);
  logic [ATTR_W-1:0] reg_q [ATTR_REGS];

  for (genvar g = 0; g < ATTR_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reg_q[g] <= '0;
      else if (wr_en && (idx == IDX_W'(g)))
        reg_q[g] <= wdata;
    end
    assign attr_flat[g*ATTR_W +: ATTR_W] = reg_q[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ATTR_REGS; i++)
      if (idx == IDX_W'(i)) rdata = reg_q[i];
  end
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
(
  input  logic [DEC_BITS-1:0]         addr_hi,   // address bits [19:14]
  input  logic                        we,
  input  logic [ATTR_REGS*ATTR_W-1:0] attr_flat,
  output logic                        to_ram
);
  logic [ATTR_W-1:0]  regs [ATTR_REGS];
  logic               in_win;
  logic               top_seg;
  logic [IDX_W-1:0]   sel;
  logic [FIELD_W-1:0] field;

  for (genvar g = 0; g < ATTR_REGS; g++) begin : g_unpack
    assign regs[g] = attr_flat[g*ATTR_W +: ATTR_W];
  end

  assign in_win  = (addr_hi[5:4] == 2'b11);
  assign top_seg = (addr_hi[5:2] == 4'hF);

  always_comb begin
    sel = top_seg ? '0 : (IDX_W'(addr_hi[3:1]) + IDX_W'(1));
    if (top_seg)
      field = regs[0][ATTR_W-1 -: FIELD_W];
    else if (addr_hi[0])
      field = regs[sel][ATTR_W-1 -: FIELD_W];
    else
      field = regs[sel][FIELD_W-1:0];
    to_ram = in_win ? (we ? field[1] : field[0]) : 1'b1;
  end
endmodule

// File: rtl/shadow_txn_ctrl.sv
module shadow_txn_ctrl
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_we,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              route_ram,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_we,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              ram_req_valid,
  input  logic              ram_req_ready,
  input  logic              ram_rsp_valid,
  input  logic [DATA_W-1:0] ram_rsp_data,
  output logic              pci_req_valid,
  input  logic              pci_req_ready,
  input  logic              pci_rsp_valid,
  input  logic [DATA_W-1:0] pci_rsp_data
);
  txn_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ram_q;
  logic [DATA_W-1:0] rdata_q;
  logic              sel_ready;
  logic              sel_rsp_valid;
  logic [DATA_W-1:0] sel_rsp_data;

  assign sel_ready     = ram_q ? ram_req_ready : pci_req_ready;
  assign sel_rsp_valid = ram_q ? ram_rsp_valid : pci_rsp_valid;
  assign sel_rsp_data  = ram_q ? ram_rsp_data  : pci_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      ram_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (up_valid) begin
          addr_q  <= up_addr;
          we_q    <= up_we;
          wdata_q <= up_wdata;
          ram_q   <= route_ram;   // target frozen at acceptance
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (sel_ready) state_q <= we_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (sel_rsp_valid) begin
          rdata_q <= sel_rsp_data;
          state_q <= ST_RESP;
        end
        ST_RESP: if (up_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign up_ready      = (state_q == ST_IDLE);
  assign ram_req_valid = (state_q == ST_ISSUE) &&  ram_q;
  assign pci_req_valid = (state_q == ST_ISSUE) && !ram_q;
  assign up_rsp_valid  = (state_q == ST_RESP);
  assign up_rsp_data   = rdata_q;
  assign dn_addr       = addr_q;
  assign dn_we         = we_q;
  assign dn_wdata      = wdata_q;
endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_we,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_we,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              ram_req_valid,
  input  logic              ram_req_ready,
  input  logic              ram_rsp_valid,
  input  logic [DATA_W-1:0] ram_rsp_data,
  output logic              pci_req_valid,
  input  logic              pci_req_ready,
  input  logic              pci_rsp_valid,
  input  logic [DATA_W-1:0] pci_rsp_data
);
  logic [ATTR_REGS*ATTR_W-1:0] attr_flat;
  logic                        route_ram;

  shadow_attr_bank bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .idx       (cfg_idx),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .attr_flat (attr_flat)
  );

  shadow_seg_decode dec_i (
    .addr_hi   (up_addr[ADDR_W-1 -: DEC_BITS]),
    .we        (up_we),
    .attr_flat (attr_flat),
    .to_ram    (route_ram)
  );

  shadow_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .up_valid      (up_valid),
    .up_ready      (up_ready),
    .up_addr       (up_addr),
    .up_we         (up_we),
    .up_wdata      (up_wdata),
    .route_ram     (route_ram),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_ready  (up_rsp_ready),
    .up_rsp_data   (up_rsp_data),
    .dn_addr       (dn_addr),
    .dn_we         (dn_we),
    .dn_wdata      (dn_wdata),
    .ram_req_valid (ram_req_valid),
    .ram_req_ready (ram_req_ready),
    .ram_rsp_valid (ram_rsp_valid),
    .ram_rsp_data  (ram_rsp_data),
    .pci_req_valid (pci_req_valid),
    .pci_req_ready (pci_req_ready),
    .pci_rsp_valid (pci_rsp_valid),
    .pci_rsp_data  (pci_rsp_data)
  );
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_data,
  input logic [ADDR_W-1:0] dn_addr,
  input logic              dn_we,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              ram_req_valid,
  input logic              ram_req_ready,
  input logic              pci_req_valid,
  input logic              pci_req_ready
);
  // R8: never both targets at once
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_req_valid && pci_req_valid));

  // R8: busy after acceptance
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> !up_ready);

  // R9: RAM request held under back-pressure
  p_ram_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && !ram_req_ready) |=>
      (ram_req_valid && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  // R9: PCI request held under back-pressure
  p_pci_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_req_ready) |=>
      (pci_req_valid && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  // R10: response held while not accepted
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_data)));

  // R6: below-window addresses go to RAM
  p_outside_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && (up_addr[ADDR_W-1 -: 2] != 2'b11)) |=> ram_req_valid);
endmodule

bind shadow_route_top shadow_route_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/shadow_route_top_tb_top.sv
module shadow_route_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [19:0] up_addr = '0;
  logic        up_we = 1'b0;
  logic [31:0] up_wdata = '0;
  logic        up_rsp_valid;
  logic        up_rsp_ready = 1'b1;
  logic [31:0] up_rsp_data;
  logic [19:0] dn_addr;
  logic        dn_we;
  logic [31:0] dn_wdata;
  logic        ram_req_valid, ram_req_ready;
  logic        ram_rsp_valid;
  logic [31:0] ram_rsp_data;
  logic        pci_req_valid, pci_req_ready;
  logic        pci_rsp_valid;
  logic [31:0] pci_rsp_data;
  logic        ram_stall = 1'b0, pci_stall = 1'b0;

  int total = 0, bad = 0;
  int ram_cnt = 0, pci_cnt = 0;
  logic [31:0] ram_mem [1024];
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shadow_route_top dut_i (.*);

  assign ram_req_ready = !ram_stall;
  assign pci_req_ready = !pci_stall;

  function automatic logic [31:0] pci_pat(input logic [19:0] a);
    return {12'hA5C, a};
  endfunction

  // target models: read data one cycle after acceptance
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_rsp_valid <= 1'b0; pci_rsp_valid <= 1'b0;
      ram_rsp_data <= '0; pci_rsp_data <= '0;
      for (int i = 0; i < 1024; i++) ram_mem[i] <= 32'h5000_0000 | i;
    end else begin
      ram_rsp_valid <= 1'b0; pci_rsp_valid <= 1'b0;
      if (ram_req_valid && ram_req_ready) begin
        ram_cnt <= ram_cnt + 1;
        if (dn_we) ram_mem[dn_addr[11:2]] <= dn_wdata;
        else begin ram_rsp_valid <= 1'b1; ram_rsp_data <= ram_mem[dn_addr[11:2]]; end
      end
      if (pci_req_valid && pci_req_ready) begin
        pci_cnt <= pci_cnt + 1;
        if (!dn_we) begin pci_rsp_valid <= 1'b1; pci_rsp_data <= pci_pat(dn_addr); end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_idx = idx[2:0]; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic access(input logic [19:0] a, input logic w, input logic [31:0] d,
                        output logic [31:0] rd, output logic tgt_ram);
    int rc0, pc0;
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    rc0 = ram_cnt; pc0 = pci_cnt;
    up_valid = 1'b1; up_addr = a; up_we = w; up_wdata = d;
    @(negedge clk);
    up_valid = 1'b0;
    rd = '0;
    if (w) begin
      while (!up_ready) @(negedge clk);
    end else begin
      while (!up_rsp_valid) @(negedge clk);
      rd = up_rsp_data;
      @(negedge clk);
    end
    tgt_ram = (ram_cnt != rc0);
    // R8: exactly one downstream request
    check(((ram_cnt - rc0) + (pci_cnt - pc0)) == 1, "R8 one downstream request",
          32'((ram_cnt - rc0) + (pci_cnt - pc0)), 32'd1);
  endtask

  function automatic logic exp_ram(input logic [19:0] a, input logic w, input int p);
    int k, m;
    if (a < 20'hC0000) return 1'b1;
    if (a >= 20'hF0000) k = 1;
    else k = 2 * (int'((a - 20'hC0000) >> 15) + 1) + int'(a[14]);
    m = (k + p) % 4;
    return w ? m[1] : m[0];
  endfunction

  initial begin
    logic [31:0] rd, hold, tmp;
    logic tr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(up_ready == 1'b1, "R1 up_ready after reset", 32'(up_ready), 32'd1);
    check(!ram_req_valid && !pci_req_valid && !up_rsp_valid, "R1 idle outputs",
          {29'd0, ram_req_valid, pci_req_valid, up_rsp_valid}, 32'd0);
    for (int r = 0; r < 7; r++) begin
      cfg_idx = r[2:0]; #1;
      check(cfg_rdata == 8'h00, "R1 register reset value", 32'(cfg_rdata), 32'd0);
    end
    access(20'hC4000, 1'b0, '0, rd, tr);
    check(tr == 1'b0, "R1 window read to PCI after reset", 32'(tr), 32'd0);
    check(rd == pci_pat(20'hC4000), "R10 PCI read data", rd, pci_pat(20'hC4000));
    access(20'hF8000, 1'b1, 32'h1234, rd, tr);
    check(tr == 1'b0, "R1 window write to PCI after reset", 32'(tr), 32'd0);

    // R3 R4 R5 R6: sweep all field-mode rotations over the window and below it
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 7; r++) begin
        logic [3:0] lo, hi;
        lo = 4'((2 * r + p) % 4);
        hi = 4'((2 * r + 1 + p) % 4);
        cfg_write(r, {hi, lo});
      end
      for (int r = 0; r < 7; r++) begin
        logic [3:0] lo, hi;
        lo = 4'((2 * r + p) % 4);
        hi = 4'((2 * r + 1 + p) % 4);
        cfg_idx = r[2:0]; #1;
        check(cfg_rdata == {hi, lo}, "R2 register readback", 32'(cfg_rdata), 32'({hi, lo}));
      end
      for (int a = 'hB8000; a < 'h100000; a += 'h800) begin
        for (int w = 0; w < 2; w++) begin
          logic [19:0] ad;
          logic e;
          ad = 20'(a + 4 * p);
          e  = exp_ram(ad, w[0], p);
          tmp = ram_mem[ad[11:2]];
          access(ad, w[0], {12'h777, ad}, rd, tr);
          check(tr == e, (ad < 20'hC0000) ? "R6 below window to RAM" :
                         (ad >= 20'hF0000) ? "R5 top segment routing" : "R3 R4 segment routing",
                32'(tr), 32'(e));
          if (!w[0])
            check(rd == (e ? tmp : pci_pat(ad)), "R10 read data from chosen target",
                  rd, e ? tmp : pci_pat(ad));
        end
      end
    end

    // R5: low field of register 0 has no routing effect
    cfg_write(0, 8'h0F);
    cfg_idx = 3'd0; #1;
    check(cfg_rdata == 8'h0F, "R2 register 0 low field readback", 32'(cfg_rdata), 32'h0F);
    access(20'hF1000, 1'b0, '0, rd, tr);
    check(tr == 1'b0, "R5 low field ignored for read", 32'(tr), 32'd0);
    access(20'hFF000, 1'b1, 32'h55, rd, tr);
    check(tr == 1'b0, "R5 low field ignored for write", 32'(tr), 32'd0);

    // R6: below window with all registers zero
    for (int r = 0; r < 7; r++) cfg_write(r, 8'h00);
    access(20'h00100, 1'b0, '0, rd, tr);
    check(tr == 1'b1, "R6 low address to RAM", 32'(tr), 32'd1);
    access(20'hBFFFC, 1'b1, 32'h9, rd, tr);
    check(tr == 1'b1, "R6 window edge to RAM", 32'(tr), 32'd1);

    // R7 R9: target frozen at acceptance, request held under stall
    pci_stall = 1'b1;
    @(negedge clk);
    up_valid = 1'b1; up_addr = 20'hC0100; up_we = 1'b0;
    @(negedge clk);
    up_valid = 1'b0;
    check(pci_req_valid && !ram_req_valid, "R7 issued to PCI", {30'd0, pci_req_valid, ram_req_valid}, 32'd2);
    cfg_write(1, 8'h33);
    for (int i = 0; i < 3; i++) begin
      check(pci_req_valid && dn_addr == 20'hC0100 && !up_ready, "R9 request held under stall",
            32'(dn_addr), 32'h000C0100);
      @(negedge clk);
    end
    pci_stall = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    check(up_rsp_data == pci_pat(20'hC0100), "R7 data from target fixed at acceptance",
          up_rsp_data, pci_pat(20'hC0100));
    @(negedge clk);
    access(20'hC0100, 1'b0, '0, rd, tr);
    check(tr == 1'b1, "R7 new mode used by next request", 32'(tr), 32'd1);

    // R12: write completion timing, no response
    ram_stall = 1'b1;
    @(negedge clk);
    up_valid = 1'b1; up_addr = 20'h00200; up_we = 1'b1; up_wdata = 32'hCAFE;
    @(negedge clk);
    up_valid = 1'b0;
    @(negedge clk);
    check(!up_ready && ram_req_valid, "R12 write pending while stalled", 32'(up_ready), 32'd0);
    ram_stall = 1'b0;
    @(negedge clk);
    check(up_ready && !up_rsp_valid, "R12 write done without response",
          {30'd0, up_ready, up_rsp_valid}, 32'd2);

    // R10: response held under back-pressure
    up_rsp_ready = 1'b0;
    @(negedge clk);
    up_valid = 1'b1; up_addr = 20'h00200; up_we = 1'b0;
    @(negedge clk);
    up_valid = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    hold = up_rsp_data;
    check(hold == 32'hCAFE, "R10 RAM read data", hold, 32'hCAFE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(up_rsp_valid && up_rsp_data == hold, "R10 response held", up_rsp_data, hold);
    end
    up_rsp_ready = 1'b1;
    @(negedge clk);
    check(!up_rsp_valid && up_ready, "R10 response released", 32'(up_rsp_valid), 32'd0);

    // R11: mode 2 copy loop, then mode 3 read-back
    cfg_write(3, 8'h22);
    for (int i = 0; i < 8; i++) begin
      logic [19:0] ad;
      ad = 20'(20'hD0040 + 4 * i);
      access(ad, 1'b0, '0, rd, tr);
      check(tr == 1'b0 && rd == pci_pat(ad), "R11 mode 2 read from PCI", rd, pci_pat(ad));
      access(ad, 1'b1, rd, tmp, tr);
      check(tr == 1'b1, "R11 mode 2 write to RAM", 32'(tr), 32'd1);
    end
    cfg_write(3, 8'h33);
    for (int i = 0; i < 8; i++) begin
      logic [19:0] ad;
      ad = 20'(20'hD0040 + 4 * i);
      access(ad, 1'b0, '0, rd, tr);
      check(tr == 1'b1 && rd == pci_pat(ad), "R11 mode 3 read returns copy", rd, pci_pat(ad));
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule